// File: doc/BRIEF.md
# Dual-Standard FSK and Tone Generator

This block turns a phase accumulator and a sine lookup into a stream of signed digital samples, one sample for each pulse of a sample-rate strobe. In FSK mode the transmit data bit picks a mark or a space frequency. A standard-select input chooses between two 1200 bit/s frequency plans. In tone mode the same oscillators produce a single or a dual tone. The tone comes from one of four tone fields that the surrounding logic supplies as phase increments.

A block enable switches the generator on and off. In tone mode an output gate also controls whether the tone reaches the output. Whenever the generator is disabled or gated off, the samples are zero and both phase accumulators are held at zero. The next tone therefore starts from phase zero. A change of frequency does not touch the accumulator, so the waveform stays phase-continuous across data-bit transitions. The block does not contain output filtering, the digital-to-analogue converter, or any tables of tone frequencies.

Top module: `fsk_tone_gen`

## Requirements
- R1: After synchronous reset, `smp_out` is 0, `smp_vld` is 0 and both phase accumulators are 0.
- R2: `smp_vld` is high for exactly one cycle, two clock edges after each cycle in which `smp_stb` is high, and it is low at all other times.
- R3: The waveform is indexed by k, the top LUT_AW bits of the accumulator. With N = 2^LUT_AW, H = N/2 and A = 2^(SW-1)-1, the value is floor(4·A·u·(H-u)/H²) with u = k for k < H. For k ≥ H it is the negative of that expression with u = k-H.
- R4: For each strobe, the sample uses the accumulator value from before that strobe. The accumulator then adds the current phase increment modulo 2^ACC_W. An increment is round(f·2^ACC_W/FS_HZ).
- R5: With `fsk_mode`=1 and `std_sel`=0, a `tx_bit` of 1 selects 1300 Hz and a `tx_bit` of 0 selects 2100 Hz.
- R6: With `fsk_mode`=1 and `std_sel`=1, a `tx_bit` of 1 selects 1200 Hz and a `tx_bit` of 0 selects 2200 Hz.
- R7: A change of frequency, whether from the data bit, the standard or the tone field, keeps the accumulator value, so the phase is continuous.
- R8: With `fsk_mode`=0, the tone field with index `tone_sel` is used. Field i takes its first increment from `tone_inc_a[i*ACC_W +: ACC_W]`, its second increment from `tone_inc_b[i*ACC_W +: ACC_W]` and its dual flag from `tone_dual[i]`.
- R9: A single tone outputs the first oscillator at full scale and holds the second accumulator at 0. A dual tone outputs (wa >>> 1) + (wb >>> 1), where >>> is an arithmetic shift.
- R10: In tone mode with `tone_gate`=0, every sample is 0 and both accumulators are cleared. After the gate reopens, the tone restarts from phase 0.
- R11: With `blk_en`=0, every sample is 0 and both accumulators are cleared, in either mode.
- R12: In FSK mode, `tone_gate` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Generator enable |
| fsk_mode | input | 1 | 1 = FSK mode, 0 = tone mode |
| std_sel | input | 1 | FSK frequency plan: 0 = 1300/2100 Hz, 1 = 1200/2200 Hz |
| tx_bit | input | 1 | Transmit data bit (1 = mark, 0 = space) |
| tone_gate | input | 1 | Tone-mode output gate |
| tone_sel | input | 2 | Tone field index |
| tone_inc_a | input | 4*ACC_W | First-oscillator increments, one per field |
| tone_inc_b | input | 4*ACC_W | Second-oscillator increments, one per field |
| tone_dual | input | 4 | Dual-tone flag, one per field |
| smp_stb | input | 1 | Sample-rate strobe |
| smp_out | output | SW | Signed output sample |
| smp_vld | output | 1 | Sample valid pulse |

## Verification
Both FSK plans are swept with constant mark and with constant space. This separates the four increments from each other and from a swapped pair. A pseudo-random bit stream is then sent through each plan. A design that resets or re-seeds the phase at a bit edge diverges from the running phase model. All four tone fields are stepped in turn, so a wrong field decode or a wrong single/dual choice shows up as a mismatch, and so does full-scale summing in place of halving. Gate-off and disable windows are followed by reopening, which shows whether the output was zeroed and the phase was cleared. FSK is also run with the gate closed to show the gate is ignored there.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  // Parabolic sine approximation for table entry k of a 2^lut_aw table.
  function automatic int wave_pt(input int k, input int lut_aw, input int amp);
    int half;
    int u;
    longint v;
    half = (1 << lut_aw) / 2;
    u = (k < half) ? k : k - half;
    v = (longint'(4) * amp * u * (half - u)) / (longint'(half) * half);
    return (k < half) ? int'(v) : -int'(v);
  endfunction

  function automatic longint phase_inc(input longint f_hz, input int acc_w, input longint fs_hz);
    return (f_hz * (longint'(1) << acc_w) + fs_hz / 2) / fs_hz;
  endfunction

endpackage

// File: rtl/ftg_inc_select.sv
module ftg_inc_select #(
  parameter int ACC_W  = 16,
  parameter int FS_HZ  = 8000,
  parameter int FLD_N  = 4,
  parameter int SEL_W  = 2
) (
  input  logic                   fsk_mode,
  input  logic                   std_sel,
  input  logic                   tx_bit,
  input  logic [SEL_W-1:0]       tone_sel,
  input  logic [FLD_N*ACC_W-1:0] tone_inc_a,
  input  logic [FLD_N*ACC_W-1:0] tone_inc_b,
  input  logic [FLD_N-1:0]       tone_dual,
  output logic [ACC_W-1:0]       inc_a,
  output logic [ACC_W-1:0]       inc_b,
  output logic                   dual
);
  localparam logic [ACC_W-1:0] INC_A_MARK  = ACC_W'(ftg_pkg::phase_inc(1300, ACC_W, FS_HZ));
  localparam logic [ACC_W-1:0] INC_A_SPACE = ACC_W'(ftg_pkg::phase_inc(2100, ACC_W, FS_HZ));
  localparam logic [ACC_W-1:0] INC_B_MARK  = ACC_W'(ftg_pkg::phase_inc(1200, ACC_W, FS_HZ));
  localparam logic [ACC_W-1:0] INC_B_SPACE = ACC_W'(ftg_pkg::phase_inc(2200, ACC_W, FS_HZ));

  logic [ACC_W-1:0] fsk_inc;
  logic [ACC_W-1:0] fld_a [FLD_N];
  logic [ACC_W-1:0] fld_b [FLD_N];

  for (genvar g = 0; g < FLD_N; g++) begin : g_fld
    assign fld_a[g] = tone_inc_a[g*ACC_W +: ACC_W];
    assign fld_b[g] = tone_inc_b[g*ACC_W +: ACC_W];
  end

  always_comb begin
    case ({std_sel, tx_bit})
      2'b00:   fsk_inc = INC_A_SPACE;
      2'b01:   fsk_inc = INC_A_MARK;
      2'b10:   fsk_inc = INC_B_SPACE;
      default: fsk_inc = INC_B_MARK;
    endcase
  end

  always_comb begin
    if (fsk_mode) begin
      inc_a = fsk_inc;
      inc_b = '0;
      dual  = 1'b0;
    end else begin
      inc_a = fld_a[tone_sel];
      inc_b = fld_b[tone_sel];
      dual  = tone_dual[tone_sel];
    end
  end

endmodule

// File: rtl/ftg_osc.sv
module ftg_osc #(
  parameter int ACC_W  = 16,
  parameter int LUT_AW = 6,
  parameter int SW     = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 stb,
  input  logic [ACC_W-1:0]     inc,
  output logic signed [SW-1:0] wave_q
);
  localparam int N   = 1 << LUT_AW;
  localparam int AMP = (1 << (SW - 1)) - 1;

  logic [ACC_W-1:0]      acc;
  logic signed [SW-1:0]  rom [N];

  initial begin
    for (int k = 0; k < N; k++) rom[k] = SW'(ftg_pkg::wave_pt(k, LUT_AW, AMP));
  end

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (!active) acc <= '0;
    else if (stb)     acc <= acc + inc;
  end

  // Registered table read, no reset, so a block RAM can hold the table.
  always_ff @(posedge clk) begin
    if (stb) wave_q <= rom[acc[ACC_W-1 -: LUT_AW]];
  end

  // R10 / R11: an inactive oscillator sits at phase zero
  p_acc_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !active |=> acc == '0);
  // R4: phase only moves on a strobe
  p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !stb) |=> $stable(acc));
  // R7: phase advances from its prior value, never re-seeded
  p_acc_step_r7: assert property (@(posedge clk) disable iff (rst)
    (active && stb) |=> acc == ACC_W'($past(acc) + $past(inc)));

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int ACC_W  = 16,
  parameter int LUT_AW = 6,
  parameter int SW     = 12,
  parameter int FS_HZ  = 8000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 blk_en,
  input  logic                 fsk_mode,
  input  logic                 std_sel,
  input  logic                 tx_bit,
  input  logic                 tone_gate,
  input  logic [1:0]           tone_sel,
  input  logic [4*ACC_W-1:0]   tone_inc_a,
  input  logic [4*ACC_W-1:0]   tone_inc_b,
  input  logic [3:0]           tone_dual,
  input  logic                 smp_stb,
  output logic [SW-1:0]        smp_out,
  output logic                 smp_vld
);
  localparam int SEL_W = 2;
  localparam int FLD_N = 1 << SEL_W;
  localparam int NOSC  = 2;

  logic [ACC_W-1:0]      inc_a, inc_b;
  logic                  dual_now;
  logic                  act_now;
  logic [NOSC-1:0]       osc_act;
  logic [ACC_W-1:0]      osc_inc [NOSC];
  logic signed [SW-1:0]  osc_q   [NOSC];
  logic                  s1_vld, s1_act, s1_dual;

  ftg_inc_select #(.ACC_W(ACC_W), .FS_HZ(FS_HZ), .FLD_N(FLD_N), .SEL_W(SEL_W)) u_sel (
    .fsk_mode   (fsk_mode),
    .std_sel    (std_sel),
    .tx_bit     (tx_bit),
    .tone_sel   (tone_sel),
    .tone_inc_a (tone_inc_a),
    .tone_inc_b (tone_inc_b),
    .tone_dual  (tone_dual),
    .inc_a      (inc_a),
    .inc_b      (inc_b),
    .dual       (dual_now)
  );

  assign act_now    = blk_en && (fsk_mode || tone_gate);
  assign osc_act[0] = act_now;
  assign osc_act[1] = act_now && dual_now;
  assign osc_inc[0] = inc_a;
  assign osc_inc[1] = inc_b;

  for (genvar g = 0; g < NOSC; g++) begin : g_osc
    ftg_osc #(.ACC_W(ACC_W), .LUT_AW(LUT_AW), .SW(SW)) u_osc (
      .clk    (clk),
      .rst    (rst),
      .active (osc_act[g]),
      .stb    (smp_stb),
      .inc    (osc_inc[g]),
      .wave_q (osc_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_act  <= 1'b0;
      s1_dual <= 1'b0;
    end else begin
      s1_vld <= smp_stb;
      if (smp_stb) begin
        s1_act  <= act_now;
        s1_dual <= dual_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_out <= '0;
      smp_vld <= 1'b0;
    end else begin
      smp_vld <= s1_vld;
      if (s1_vld) begin
        if (!s1_act)     smp_out <= '0;
        else if (s1_dual) smp_out <= (osc_q[0] >>> 1) + (osc_q[1] >>> 1);
        else              smp_out <= osc_q[0];
      end
    end
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: valid trails the strobe by two edges
  p_vld_lag_r2: assert property (@(posedge clk) disable iff (rst)
    since_rst == 2'd3 |-> smp_vld == $past(smp_stb, 2));
  // R11: a disabled generator emits zero
  p_zero_off_r11: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(smp_stb, 2) && !$past(blk_en, 2)) |-> smp_out == '0);
  // R1: nothing valid right out of reset
  p_rst_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!smp_vld && smp_out == '0));

endmodule

// File: tb/sim_fsk_tone_gen.sv
`timescale 1ns/1ps
module sim_fsk_tone_gen;
  localparam int ACC_W = 16;
  localparam int LUT_AW = 6;
  localparam int SW = 12;
  localparam int FS = 8000;

  logic clk = 0;
  logic rst = 1;
  logic blk_en = 0, fsk_mode = 0, std_sel = 0, tx_bit = 0, tone_gate = 0;
  logic [1:0] tone_sel = 0;
  logic [4*ACC_W-1:0] tone_inc_a, tone_inc_b;
  logic [3:0] tone_dual;
  logic smp_stb = 0;
  logic [SW-1:0] smp_out;
  logic smp_vld;

  int n_chk = 0, n_bad = 0;
  int pa = 0, pb = 0;
  bit finished = 0;
  int nonzero = 0;

  always #2.5 clk = ~clk;

  fsk_tone_gen #(.ACC_W(ACC_W), .LUT_AW(LUT_AW), .SW(SW), .FS_HZ(FS)) u0 (
    .clk(clk), .rst(rst), .blk_en(blk_en), .fsk_mode(fsk_mode), .std_sel(std_sel),
    .tx_bit(tx_bit), .tone_gate(tone_gate), .tone_sel(tone_sel),
    .tone_inc_a(tone_inc_a), .tone_inc_b(tone_inc_b), .tone_dual(tone_dual),
    .smp_stb(smp_stb), .smp_out(smp_out), .smp_vld(smp_vld)
  );

  function automatic int incf(input int f);
    return (f * 65536 + FS / 2) / FS;
  endfunction

  function automatic int wv(input int k);
    int h, u, a, v;
    h = 32; a = 2047;
    u = (k < h) ? k : k - h;
    v = (4 * a * u * (h - u)) / (h * h);
    return (k < h) ? v : -v;
  endfunction

  function automatic int fsk_f(input bit s, input bit b);
    if (!s) return b ? 1300 : 2100;
    return b ? 1200 : 2200;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_act();
    return blk_en && (fsk_mode || tone_gate);
  endfunction

  function automatic bit m_dual();
    return !fsk_mode && tone_dual[tone_sel];
  endfunction

  task automatic cfg(input bit en, input bit fm, input bit sd, input bit tb,
                     input bit gt, input int sel);
    @(posedge clk); #1;
    blk_en = en; fsk_mode = fm; std_sel = sd; tx_bit = tb; tone_gate = gt;
    tone_sel = 2'(sel);
    if (!m_act()) begin pa = 0; pb = 0; end
    else if (!m_dual()) pb = 0;
  endtask

  task automatic strobe(input string req);
    int e, ia, ib;
    if (!m_act()) e = 0;
    else begin
      ia = fsk_mode ? incf(fsk_f(std_sel, tx_bit)) : int'(tone_inc_a[tone_sel*ACC_W +: ACC_W]);
      ib = int'(tone_inc_b[tone_sel*ACC_W +: ACC_W]);
      if (m_dual()) begin
        e = (wv(pa >> 10) >>> 1) + (wv(pb >> 10) >>> 1);
        pb = (pb + ib) & 16'hffff;
      end else e = wv(pa >> 10);
      pa = (pa + ia) & 16'hffff;
    end
    @(posedge clk); #1 smp_stb = 1;
    @(posedge clk); #1 smp_stb = 0;
    chk("R2 vld low", int'(smp_vld), 0);
    @(posedge clk); #1;
    chk("R2 vld high", int'(smp_vld), 1);
    chk(req, int'($signed(smp_out)), e);
    if (smp_out != 0) nonzero++;
  endtask

  initial begin
    tone_inc_a = {16'(incf(440)), 16'(incf(852)), 16'(incf(1000)), 16'(incf(697))};
    tone_inc_b = {16'(incf(0)),   16'(incf(1477)), 16'(0),        16'(incf(1209))};
    tone_dual = 4'b0101;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;
    chk("R1 out", int'(smp_out), 0);
    chk("R1 vld", int'(smp_vld), 0);
    // R3 R4 R5: V.23-style plan, constant mark then space
    cfg(1, 1, 0, 1, 1, 0);
    for (int i = 0; i < 40; i++) strobe("R5 mark");
    cfg(1, 1, 0, 0, 1, 0);
    for (int i = 0; i < 40; i++) strobe("R5 space");
    // R6: other plan
    cfg(1, 1, 1, 1, 1, 0);
    for (int i = 0; i < 40; i++) strobe("R6 mark");
    cfg(1, 1, 1, 0, 1, 0);
    for (int i = 0; i < 40; i++) strobe("R6 space");
    // R7: random bits, phase continuous
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 64; i++) begin
        cfg(1, 1, 1'(s), 1'($urandom_range(0, 1)), 1, 0);
        strobe("R7 continuity");
      end
    // R8 R9: tone fields, single and dual
    for (int f = 0; f < 4; f++) begin
      cfg(1, 0, 0, 0, 1, f);
      for (int i = 0; i < 30; i++) strobe(tone_dual[f] ? "R9 dual" : "R8 single");
    end
    // R10: gate closed then reopened
    cfg(1, 0, 0, 0, 0, 2);
    for (int i = 0; i < 5; i++) strobe("R10 gated");
    cfg(1, 0, 0, 0, 1, 2);
    for (int i = 0; i < 10; i++) strobe("R10 restart");
    // R11: disable in both modes
    cfg(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 5; i++) strobe("R11 off tone");
    cfg(0, 1, 0, 1, 1, 0);
    for (int i = 0; i < 5; i++) strobe("R11 off fsk");
    cfg(1, 1, 0, 1, 1, 0);
    for (int i = 0; i < 8; i++) strobe("R11 restart");
    // R12: FSK ignores the gate
    nonzero = 0;
    cfg(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 20; i++) strobe("R12 gate ignored");
    chk("R12 nonzero", int'(nonzero > 0), 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule